// File: doc/BRIEF.md
# Vendor-diverse dual modular redundant datapath

The block evaluates a fixed second-order recursive filter step twice, once in an original unit and once in a duplicate unit. Both copies run at the same time on one shared pool of functional units: two adders and two multipliers. Each of the two "vendors" supplies one adder and one multiplier. Every operation of the graph is bound so that it and its duplicate run on units from different vendors. A malicious unit from one vendor therefore makes the two copies disagree.

Once both copies have finished, the block compares only their two final outputs. It presents the original unit's outputs together with a detect flag. The graph has five operations per copy. In graph order they are:

- M1 = c1*s1
- M2 = c2*s2
- A1 = x+M1
- A2 = A1+M2
- A3 = A2+s1

The outputs are y0 = A2 and y1 = A3. A static mode input selects one of two vendor binding policies. For test, the vendor-1 adder has a dormant tamper input, driven from the `trig` pin.

The block uses valid/ready streams on both sides and takes one job at a time:

- **Input side:** `in_ready` is high only while the block is idle. The operands and `mode` are captured on the cycle where `in_valid` and `in_ready` are both high.
- **Output side:** `out_valid` stays high, with all outputs frozen, until the cycle in which `out_ready` is high. The block then returns to idle.

Top module: `dmr_checker`

## Requirements
- R1: With `trig` low, in both modes, the block returns `out_y0` = x + c1*s1 + c2*s2 and `out_y1` = `out_y0` + s1, both modulo 2^W, with `out_detect` = 0.
- R2: When `mode` = 1, every original-unit operation uses a vendor-1 unit and every duplicate-unit operation uses a vendor-2 unit. With `trig` high the vendor-1 adder computes a − b, and `out_y0`/`out_y1` always carry the original unit's values.
- R3: When `mode` = 0, the operations of each type are numbered k = 0, 1, … in graph order. For multipliers this is M1, M2; for adders it is A1, A2, A3. The original copy of operation k uses vendor 1 when k is even and vendor 2 when k is odd. The duplicate copy always uses the other vendor.
- R4: `out_detect` is 1 exactly when the original and duplicate values differ for A2 or for A3. Intermediate values are never compared, so a tampered adder whose final outputs still agree raises no flag.
- R5: A free unit goes first to an original-unit operation, and then to the lowest operation in graph order. With multiplier latency L, `mode` = 0 therefore gives `out_valid` high 2L+3 cycles after the accepting edge.
- R6: An addition occupies its adder for one cycle. A multiplication holds its multiplier for MUL_LAT cycles and releases it on the write. With `mode` = 1, `out_valid` rises 2L+2 cycles after the accepting edge.
- R7: `in_ready` is high only while idle. An `in_valid` asserted while `in_ready` is low is ignored and does not alter the job in flight.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_y0`, `out_y1` and `out_detect` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block idle, operands accepted |
| in_x | input | W | Filter input sample |
| in_c1 | input | W | First feedback coefficient |
| in_c2 | input | W | Second feedback coefficient |
| in_s1 | input | W | First state value |
| in_s2 | input | W | Second state value |
| mode | input | 1 | Vendor binding policy, captured with the operands |
| trig | input | 1 | Dormant tamper input of the vendor-1 adder |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_y0 | output | W | Original unit A2 value |
| out_y1 | output | W | Original unit A3 value |
| out_detect | output | 1 | Final-output mismatch between the units |

## Verification
The bench builds the block with W = 16, MUL_LAT = 3 and the tamper variant enabled. This brings the exact latency targets within reach: 8 cycles in mode 1 and 9 cycles in mode 0, the extra cycle coming from original-first arbitration. It also makes the 16-bit wrap boundary reachable, where a − b equals a + b and a tampered run must stay silent. Random operands are run with the trigger off and on in both modes, under random output stalls and with spurious input offers while the block is busy.

// File: rtl/dmr_pkg.sv
`timescale 1ns/1ps
package dmr_pkg;
  localparam int OPS    = 5;           // operations per copy
  localparam int COPIES = 2;           // original, duplicate
  localparam int NSLOT  = OPS * COPIES;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int NMUL   = 2;           // multiply operations per copy
  localparam int J_Y0   = 3;           // A2
  localparam int J_Y1   = 4;           // A3

  function automatic logic op_is_mul(input int j);
    return (j < NMUL);
  endfunction

  // index of the operation among those of its own type
  function automatic int type_rank(input int j);
    return op_is_mul(j) ? j : j - NMUL;
  endfunction

  // vendor index (0 = vendor 1, 1 = vendor 2) for copy u, op j
  function automatic logic vendor_of(input int u, input int j, input logic whole);
    logic dup;
    dup = (u != 0);
    if (whole) return dup;
    return ((type_rank(j) % 2) != 0) ^ dup;
  endfunction
endpackage

// File: rtl/dmr_add.sv
`timescale 1ns/1ps
module dmr_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         tamper,
  output logic [W-1:0] sum
);
  always_comb sum = tamper ? (a - b) : (a + b);
endmodule

// File: rtl/dmr_mul.sv
`timescale 1ns/1ps
module dmr_mul import dmr_pkg::*; #(
  parameter int W   = 16,
  parameter int LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [SLOT_W-1:0] slot,
  output logic              busy,
  output logic              wr,
  output logic [SLOT_W-1:0] wslot,
  output logic [W-1:0]      wdata
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  ra, rb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      wslot <= '0;
    end else if (issue) begin
      busy  <= 1'b1;
      cnt   <= CW'(1);
      wslot <= slot;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      else             cnt  <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (issue) begin
      ra <= a;
      rb <= b;
    end
  end

  assign wr    = busy && (cnt == LAST);
  assign wdata = ra * rb;

  // R6: a held multiplier is never handed a new operation
  p_unit_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !issue);
  // R6: the unit frees itself in the cycle after its write
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !issue) |=> !busy);
endmodule

// File: rtl/dmr_sched.sv
`timescale 1ns/1ps
module dmr_sched import dmr_pkg::*; #(
  parameter int NV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              whole,
  input  logic [NSLOT-1:0]  done,
  input  logic [NSLOT-1:0]  issued,
  input  logic [NV-1:0]     mul_busy,
  output logic [NV-1:0]     add_gv,
  output logic [SLOT_W-1:0] add_gs [NV],
  output logic [NV-1:0]     mul_gv,
  output logic [SLOT_W-1:0] mul_gs [NV]
);
  logic [NSLOT-1:0] ready;

  always_comb begin
    for (int g = 0; g < NSLOT; g++) begin
      int u, j, base;
      logic dep;
      u    = g / OPS;
      j    = g % OPS;
      base = u * OPS;
      case (j)
        2:       dep = done[base];
        3:       dep = done[base+2] & done[base+1];
        4:       dep = done[base+3];
        default: dep = 1'b1;
      endcase
      ready[g] = run && !issued[g] && dep;
    end
  end

  // lowest slot wins: original copy first, then graph order
  always_comb begin
    for (int v = 0; v < NV; v++) begin
      add_gv[v] = 1'b0;
      add_gs[v] = '0;
      mul_gv[v] = 1'b0;
      mul_gs[v] = '0;
      for (int g = 0; g < NSLOT; g++) begin
        if (ready[g] && (vendor_of(g / OPS, g % OPS, whole) == (v != 0))) begin
          if (op_is_mul(g % OPS)) begin
            if (!mul_gv[v] && !mul_busy[v]) begin
              mul_gv[v] = 1'b1;
              mul_gs[v] = SLOT_W'(g);
            end
          end else if (!add_gv[v]) begin
            add_gv[v] = 1'b1;
            add_gs[v] = SLOT_W'(g);
          end
        end
      end
    end
  end

  // R5: within one cycle both adders never start the same operation
  p_distinct_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (add_gv[0] && add_gv[1]) |-> (add_gs[0] != add_gs[1]));
  // R6: nothing starts while no job is running
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (add_gv == '0 && mul_gv == '0));
endmodule

// File: rtl/dmr_checker.sv
`timescale 1ns/1ps
module dmr_checker import dmr_pkg::*; #(
  parameter int W           = 16,
  parameter int MUL_LAT     = 3,
  parameter int TEST_TAMPER = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_c1,
  input  logic [W-1:0] in_c2,
  input  logic [W-1:0] in_s1,
  input  logic [W-1:0] in_s2,
  input  logic         mode,
  input  logic         trig,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_y0,
  output logic [W-1:0] out_y1,
  output logic         out_detect
);
  localparam int NV = 2;

  typedef enum logic {S_IDLE, S_RUN} st_e;
  st_e st;

  logic [W-1:0] rx, rc1, rc2, rs1, rs2;
  logic         rwhole;
  logic [W-1:0] bank [NSLOT];
  logic [NSLOT-1:0] done, issued;
  logic [W-1:0] op_a [NSLOT];
  logic [W-1:0] op_b [NSLOT];

  logic [NV-1:0]     add_gv, mul_gv, mul_busy, mul_wr;
  logic [SLOT_W-1:0] add_gs [NV];
  logic [SLOT_W-1:0] mul_gs [NV];
  logic [SLOT_W-1:0] mul_ws [NV];
  logic [W-1:0]      add_sum [NV];
  logic [W-1:0]      mul_wd [NV];

  logic accept, retire, run;
  assign in_ready  = (st == S_IDLE);
  assign accept    = in_valid && in_ready;
  assign run       = (st == S_RUN);
  assign out_valid = run && (&done);
  assign retire    = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st <= S_IDLE;
    else if (accept) st <= S_RUN;
    else if (retire) st <= S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      rx     <= in_x;
      rc1    <= in_c1;
      rc2    <= in_c2;
      rs1    <= in_s1;
      rs2    <= in_s2;
      rwhole <= mode;
    end
  end

  // separate operand banks for each copy
  for (genvar u = 0; u < COPIES; u++) begin : g_copy
    localparam int B = u * OPS;
    assign op_a[B+0] = rc1;        assign op_b[B+0] = rs1;
    assign op_a[B+1] = rc2;        assign op_b[B+1] = rs2;
    assign op_a[B+2] = rx;         assign op_b[B+2] = bank[B+0];
    assign op_a[B+3] = bank[B+2];  assign op_b[B+3] = bank[B+1];
    assign op_a[B+4] = bank[B+3];  assign op_b[B+4] = rs1;
  end

  dmr_sched #(.NV(NV)) u_sched (
    .clk(clk), .rst_n(rst_n), .run(run), .whole(rwhole),
    .done(done), .issued(issued), .mul_busy(mul_busy),
    .add_gv(add_gv), .add_gs(add_gs), .mul_gv(mul_gv), .mul_gs(mul_gs)
  );

  for (genvar v = 0; v < NV; v++) begin : g_vendor
    logic tamper;
    if (v == 0 && TEST_TAMPER != 0) begin : g_tamper
      assign tamper = trig;
    end else begin : g_clean
      assign tamper = 1'b0;
    end

    dmr_add #(.W(W)) u_add (
      .a(op_a[add_gs[v]]), .b(op_b[add_gs[v]]),
      .tamper(tamper), .sum(add_sum[v])
    );

    dmr_mul #(.W(W), .LAT(MUL_LAT)) u_mul (
      .clk(clk), .rst_n(rst_n), .issue(mul_gv[v]),
      .a(op_a[mul_gs[v]]), .b(op_b[mul_gs[v]]), .slot(mul_gs[v]),
      .busy(mul_busy[v]), .wr(mul_wr[v]), .wslot(mul_ws[v]), .wdata(mul_wd[v])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= '0;
      issued <= '0;
    end else if (accept) begin
      done   <= '0;
      issued <= '0;
    end else begin
      for (int v = 0; v < NV; v++) begin
        if (add_gv[v]) begin
          issued[add_gs[v]] <= 1'b1;
          done[add_gs[v]]   <= 1'b1;
        end
        if (mul_gv[v]) issued[mul_gs[v]] <= 1'b1;
        if (mul_wr[v]) done[mul_ws[v]]   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int v = 0; v < NV; v++) begin
      if (add_gv[v]) bank[add_gs[v]] <= add_sum[v];
      if (mul_wr[v]) bank[mul_ws[v]] <= mul_wd[v];
    end
  end

  // final outputs only, pair by pair
  assign out_y0     = bank[J_Y0];
  assign out_y1     = bank[J_Y1];
  assign out_detect = (bank[J_Y0] != bank[OPS+J_Y0]) ||
                      (bank[J_Y1] != bank[OPS+J_Y1]);

  // R8: a stalled result stays put
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_y0) &&
                                   $stable(out_y1) && $stable(out_detect)));
  // R7: never ready for a new job while a result is pending
  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);
  // R1: each bank slot is written at most once per job
  p_write_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mul_wr[0] |-> !done[mul_ws[0]]);
  // R6: results only arrive while a job is running
  p_write_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|mul_wr) |-> run);
endmodule

// File: tb/dmr_checker_test.sv
`timescale 1ns/1ps
module dmr_checker_test;
  localparam int W = 16;
  localparam int L = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, mode = 1'b0, trig = 1'b0, out_ready = 1'b1;
  logic [W-1:0] in_x = '0, in_c1 = '0, in_c2 = '0, in_s1 = '0, in_s2 = '0;
  logic in_ready, out_valid, out_detect;
  logic [W-1:0] out_y0, out_y1;

  always #2 clk = ~clk;

  dmr_checker #(.W(W), .MUL_LAT(L), .TEST_TAMPER(1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_c1(in_c1), .in_c2(in_c2), .in_s1(in_s1), .in_s2(in_s2),
    .mode(mode), .trig(trig), .out_valid(out_valid), .out_ready(out_ready),
    .out_y0(out_y0), .out_y1(out_y1), .out_detect(out_detect)
  );

  typedef struct {
    logic [W-1:0] y0, y1;
    logic         det;
    int           lat;
    string        req;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, errors = 0, cyc = 0, acc_cyc = 0;
  bit seen = 0, stall_on = 0;
  logic [W-1:0] hy0, hy1;
  logic hdet;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [W-1:0] vadd(input logic [W-1:0] a, b,
                                        input logic ven, input logic tr);
    return (tr && !ven) ? a - b : a + b;
  endfunction

  // vendor of add rank k for copy u, per R2 and R3
  function automatic logic aven(input int u, input int k, input logic md);
    return md ? (u != 0) : (((k % 2) != 0) ^ (u != 0));
  endfunction

  task automatic send(input logic [W-1:0] x, c1, c2, s1, s2,
                      input logic md, input logic tr, input string req);
    exp_t e;
    logic [W-1:0] m1, m2, a1, a2, a3, o2, o3;
    m1 = c1 * s1;
    m2 = c2 * s2;
    for (int u = 0; u < 2; u++) begin
      a1 = vadd(x,  m1, aven(u, 0, md), tr);
      a2 = vadd(a1, m2, aven(u, 1, md), tr);
      a3 = vadd(a2, s1, aven(u, 2, md), tr);
      if (u == 0) begin o2 = a2; o3 = a3; end
    end
    e.y0 = o2; e.y1 = o3;
    e.det = (o2 != a2) || (o3 != a3);
    e.lat = md ? 2*L + 2 : 2*L + 3;
    e.req = req;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_x = x; in_c1 = c1; in_c2 = c2; in_s1 = s1; in_s2 = s2;
    mode = md; trig = tr; in_valid = 1'b1;
    exp_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_valid && in_ready) acc_cyc = cyc + 1;
      if (out_valid && exp_q.size() != 0) begin
        if (!seen) begin
          chk(exp_q[0].lat == 2*L+2 ? "R6" : "R5", "latency",
              cyc - acc_cyc, exp_q[0].lat);
          seen = 1;
        end else begin
          chk("R8", "held y0", out_y0, hy0);
          chk("R8", "held detect", out_detect, hdet);
        end
        hy0 = out_y0; hy1 = out_y1; hdet = out_detect;
        if (out_ready) begin
          chk(exp_q[0].req, "y0", out_y0, exp_q[0].y0);
          chk(exp_q[0].req, "y1", out_y1, exp_q[0].y1);
          chk("R4", "detect", out_detect, exp_q[0].det);
          void'(exp_q.pop_front());
          seen = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    #1 out_ready <= stall_on ? ($urandom_range(0, 2) == 0) : 1'b1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7", "reset in_ready", in_ready, 1);
    chk("R8", "reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    // R1 directed: 1 + 2*3 + 4*5 = 27, then 30
    send(1, 2, 4, 3, 5, 1'b1, 1'b0, "R1");
    send(1, 2, 4, 3, 5, 1'b0, 1'b0, "R1");
    // R4 boundary: tamper active but a-b == a+b at every adder
    send(16'h1234, 0, 0, 16'h8000, 7, 1'b1, 1'b1, "R4");
    send(16'h1234, 0, 0, 16'h8000, 7, 1'b0, 1'b1, "R4");
    // R2 / R3 directed with tamper
    send(10, 1, 1, 2, 3, 1'b1, 1'b1, "R2");
    send(10, 1, 1, 2, 3, 1'b0, 1'b1, "R3");
    stall_on = 1;
    for (int i = 0; i < 40; i++) begin
      logic md, tr;
      md = i[0];
      tr = i[1];
      send(W'($urandom), W'($urandom), W'($urandom), W'($urandom), W'($urandom),
           md, tr, tr ? (md ? "R2" : "R3") : "R1");
    end
    // R7: offers while busy are ignored
    fork
      send(5, 6, 7, 8, 9, 1'b0, 1'b0, "R7");
      begin
        repeat (3) @(negedge clk);
        in_x = 16'hdead; in_c1 = 16'hbeef; in_s1 = 16'h55; in_valid = 1'b1;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
      end
    join
    stall_on = 0;
    repeat (5) @(negedge clk);
    chk("R7", "idle in_ready", in_ready, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule